// File: doc/BRIEF.md
# Cartridge Bus Address Bridge

This block lets a host read and program a console game cartridge as if it were a plain 64 KiB byte-wide memory. The host drives an address, write data, an active-low chip enable and active-low read and write strobes. The bridge turns each accepted access into one timed cartridge cycle. Host address bit 15 decides where that cycle goes. The lower half becomes a read on the character-side bus, which holds pattern memory. The upper half becomes a cycle on the program-side bus, which has a phase-2 clock, an active-low ROM select and a read/write line.

A host write to the upper half becomes a program-side write cycle. Mapper registers on the cartridge latch the data exactly as they would inside the console, so the host can switch banks and then read the newly mapped bytes back. A host write to the lower half is acknowledged to the host but never reaches the cartridge. A DMA/address-enable qualifier can hold off every access. As an option, the start of a cycle can also be tied to an address-latch-enable input. The bridge controls the direction and the enable of the external data transceiver.

Top module: `cart_bus_bridge`

## Requirements
- R1: After reset, `prg_m2` and `host_ack` are low; `prg_romsel_n`, `chr_rd_n`, `chr_wr_n` and `xcvr_oe_n` are high; and `host_rdata` is 0.
- R2: A host read with `host_addr[15]`=1 produces a program-side cycle. During that cycle `prg_romsel_n` is low only while `prg_m2` is high, `prg_rw` stays high, `prg_addr` equals `host_addr[14:0]`, and the returned byte is the one the cartridge drives.
- R3: A host read with `host_addr[15]`=0 asserts `chr_rd_n` low during the active phase. `chr_addr` equals `host_addr[12:0]` and `chr_tbl_sel` is 0 (pattern memory). `host_addr[14:13]` are ignored, so those addresses alias. `prg_romsel_n` stays high.
- R4: A host write with `host_addr[15]`=1 drives `prg_rw` low and `prg_romsel_n` low while `prg_m2` is high. `xcvr_dir`=1 (toward the cartridge) and `xcvr_oe_n`=0 hold during that phase, with `cart_d_out` equal to the host data. `xcvr_dir` is never 1 while `xcvr_oe_n` is high.
- R5: A host write with `host_addr[15]`=0 is acknowledged, but asserts neither `prg_romsel_n`, `chr_rd_n` nor `chr_wr_n`. It never pulls `prg_rw` low, never enables the transceiver, and leaves mapper state unchanged.
- R6: For every accepted access, `prg_m2` is high for exactly ACT_CLKS consecutive clocks.
- R7: Between two accesses, `prg_m2` stays low for at least REC_CLKS clocks. A new access starts only after the host has released its strobe or chip enable at least once.
- R8: `host_ack` is a one-clock pulse in the cycle in which `prg_m2` falls. `host_rdata` takes the cartridge byte captured on the last active clock of a read, and keeps its value through writes.
- R9: While `host_aen` is high (with AEN_GATE=1), no cycle starts. A request with both strobes low is also ignored, so no `prg_m2` pulse and no `host_ack` follow.
- R10: With TRIG_ALE=1, a request starts a cycle only in a clock where `host_ale` is high. With TRIG_ALE=0, `host_ale` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_aen | input | 1 | DMA/address-enable qualifier, blocks access when high |
| host_ale | input | 1 | Address latch enable, cycle trigger when TRIG_ALE=1 |
| host_rdata | output | 8 | Captured read byte |
| host_ack | output | 1 | One-clock completion pulse |
| prg_m2 | output | 1 | Program-side phase-2 cycle clock |
| prg_romsel_n | output | 1 | Program ROM select, active low |
| prg_rw | output | 1 | Program-side read (1) / write (0) |
| prg_addr | output | 15 | Program-side address |
| chr_addr | output | 13 | Character-side address |
| chr_rd_n | output | 1 | Character read strobe, active low |
| chr_wr_n | output | 1 | Character write strobe, active low (held inactive) |
| chr_tbl_sel | output | 1 | Character space select, 0 = pattern memory |
| cart_d_in | input | 8 | Byte from the cartridge side of the transceiver |
| cart_d_out | output | 8 | Byte driven toward the cartridge |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward the cartridge |
| xcvr_oe_n | output | 1 | Transceiver enable, active low |

## Verification
The bench builds the bridge with ACT_CLKS=5 and REC_CLKS=3 rather than the defaults. Both counters therefore run through limits other than the shortest legal ones, and the phase-width and recovery-gap checks are tested against a non-trivial value. AEN_GATE stays at 1, so the qualifier path is reachable. Back-to-back accesses reach the recovery window, and mapper writes followed by program reads show that bank data travels through the bus.

// File: rtl/cbb_pkg.sv
package cbb_pkg;

    localparam int HOST_AW = 16;
    localparam int PRG_AW  = 15;
    localparam int CHR_AW  = 13;
    localparam int DW      = 8;

    typedef enum logic [1:0] {
        ACC_CHR_RD = 2'd0,
        ACC_PRG_RD = 2'd1,
        ACC_PRG_WR = 2'd2,
        ACC_DROP   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_RECOV  = 2'd2
    } seq_state_e;

    typedef struct packed {
        acc_kind_e          kind;
        logic [PRG_AW-1:0]  addr;
        logic [DW-1:0]      wdata;
    } acc_req_t;

    // Route by the top host address bit and the access direction.
    function automatic acc_kind_e classify(input logic upper, input logic is_wr);
        acc_kind_e k;
        case ({upper, is_wr})
            2'b00:   k = ACC_CHR_RD;
            2'b10:   k = ACC_PRG_RD;
            2'b11:   k = ACC_PRG_WR;
            default: k = ACC_DROP;
        endcase
        return k;
    endfunction

    function automatic logic is_read(input acc_kind_e k);
        return (k == ACC_CHR_RD) || (k == ACC_PRG_RD);
    endfunction

endpackage

// File: rtl/cbb_host_decode.sv
module cbb_host_decode
    import cbb_pkg::*;
#(
    parameter bit AEN_GATE = 1'b1,
    parameter bit TRIG_ALE = 1'b0
) (
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DW-1:0]      host_wdata,
    input  logic               host_ce_n,
    input  logic               host_rd_n,
    input  logic               host_wr_n,
    input  logic               host_aen,
    input  logic               host_ale,
    output logic               req_valid,
    output logic               req_any,
    output acc_req_t           req
);
    logic well_formed;
    logic gate_ok;
    logic trig_ok;

    // Any strobe held with chip enable counts as "not yet released".
    assign req_any     = !host_ce_n && (!host_rd_n || !host_wr_n);
    // Exactly one strobe may be active for a legal request.
    assign well_formed = !host_ce_n && (host_rd_n ^ host_wr_n);
    assign gate_ok     = AEN_GATE ? !host_aen : 1'b1;
    assign trig_ok     = TRIG_ALE ? host_ale : 1'b1;
    assign req_valid   = well_formed && gate_ok && trig_ok;

    always_comb begin
        req.kind  = classify(host_addr[HOST_AW-1], !host_wr_n);
        req.addr  = host_addr[PRG_AW-1:0];
        req.wdata = host_wdata;
    end

endmodule

// File: rtl/cbb_cycle_timer.sv
module cbb_cycle_timer
    import cbb_pkg::*;
#(
    parameter int ACT_CLKS = 4,
    parameter int REC_CLKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_any,
    output logic start,
    output logic finish,
    output logic active
);
    localparam int MAXC = (ACT_CLKS > REC_CLKS) ? ACT_CLKS : REC_CLKS;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] ACT_LAST = CW'(ACT_CLKS - 1);
    localparam logic [CW-1:0] REC_LAST = CW'(REC_CLKS - 1);

    seq_state_e      state;
    logic [CW-1:0]   cnt;
    logic            released;

    assign start  = (state == ST_IDLE) && req_valid;
    assign active = (state == ST_ACTIVE);
    assign finish = active && (cnt == ACT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            released <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state <= ST_ACTIVE;
                        cnt   <= '0;
                    end
                end
                ST_ACTIVE: begin
                    if (cnt == ACT_LAST) begin
                        state    <= ST_RECOV;
                        cnt      <= '0;
                        released <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RECOV: begin
                    released <= released || !req_any;
                    if (cnt != REC_LAST) begin
                        cnt <= cnt + 1'b1;
                    end else if (released || !req_any) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cbb_bus_drive.sv
module cbb_bus_drive
    import cbb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               finish,
    input  logic               active,
    input  acc_req_t           req_in,
    input  logic [DW-1:0]      cart_d_in,
    output logic [DW-1:0]      host_rdata,
    output logic               host_ack,
    output logic               prg_m2,
    output logic               prg_romsel_n,
    output logic               prg_rw,
    output logic [PRG_AW-1:0]  prg_addr,
    output logic [CHR_AW-1:0]  chr_addr,
    output logic               chr_rd_n,
    output logic               chr_wr_n,
    output logic               chr_tbl_sel,
    output logic [DW-1:0]      cart_d_out,
    output logic               xcvr_dir,
    output logic               xcvr_oe_n
);
    acc_req_t cur;
    logic     prg_side;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur        <= '{kind: ACC_DROP, addr: '0, wdata: '0};
            host_rdata <= '0;
            host_ack   <= 1'b0;
        end else begin
            host_ack <= finish;
            if (start) begin
                cur <= req_in;
            end
            if (finish && is_read(cur.kind)) begin
                host_rdata <= cart_d_in;
            end
        end
    end

    assign prg_side     = (cur.kind == ACC_PRG_RD) || (cur.kind == ACC_PRG_WR);
    assign prg_m2       = active;
    assign prg_romsel_n = !(active && prg_side);
    assign prg_rw       = !(active && (cur.kind == ACC_PRG_WR));
    assign prg_addr     = cur.addr;
    assign chr_addr     = cur.addr[CHR_AW-1:0];
    assign chr_rd_n     = !(active && (cur.kind == ACC_CHR_RD));
    assign chr_wr_n     = 1'b1;
    assign chr_tbl_sel  = 1'b0;
    assign cart_d_out   = cur.wdata;
    assign xcvr_dir     = active && (cur.kind == ACC_PRG_WR);
    assign xcvr_oe_n    = !(active && (cur.kind != ACC_DROP));

endmodule

// File: rtl/cart_bus_bridge.sv
module cart_bus_bridge
    import cbb_pkg::*;
#(
    parameter int ACT_CLKS = 4,
    parameter int REC_CLKS = 2,
    parameter bit AEN_GATE = 1'b1,
    parameter bit TRIG_ALE = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] host_addr,
    input  logic [7:0]  host_wdata,
    input  logic        host_ce_n,
    input  logic        host_rd_n,
    input  logic        host_wr_n,
    input  logic        host_aen,
    input  logic        host_ale,
    output logic [7:0]  host_rdata,
    output logic        host_ack,
    output logic        prg_m2,
    output logic        prg_romsel_n,
    output logic        prg_rw,
    output logic [14:0] prg_addr,
    output logic [12:0] chr_addr,
    output logic        chr_rd_n,
    output logic        chr_wr_n,
    output logic        chr_tbl_sel,
    input  logic [7:0]  cart_d_in,
    output logic [7:0]  cart_d_out,
    output logic        xcvr_dir,
    output logic        xcvr_oe_n
);
    logic     req_valid;
    logic     req_any;
    acc_req_t req;
    logic     start;
    logic     finish;
    logic     active;

    cbb_host_decode #(.AEN_GATE(AEN_GATE), .TRIG_ALE(TRIG_ALE)) dec_i (
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_ce_n (host_ce_n),
        .host_rd_n (host_rd_n),
        .host_wr_n (host_wr_n),
        .host_aen  (host_aen),
        .host_ale  (host_ale),
        .req_valid (req_valid),
        .req_any   (req_any),
        .req       (req)
    );

    cbb_cycle_timer #(.ACT_CLKS(ACT_CLKS), .REC_CLKS(REC_CLKS)) tmr_i (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_any  (req_any),
        .start    (start),
        .finish   (finish),
        .active   (active)
    );

    cbb_bus_drive drv_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .finish      (finish),
        .active      (active),
        .req_in      (req),
        .cart_d_in   (cart_d_in),
        .host_rdata  (host_rdata),
        .host_ack    (host_ack),
        .prg_m2      (prg_m2),
        .prg_romsel_n(prg_romsel_n),
        .prg_rw      (prg_rw),
        .prg_addr    (prg_addr),
        .chr_addr    (chr_addr),
        .chr_rd_n    (chr_rd_n),
        .chr_wr_n    (chr_wr_n),
        .chr_tbl_sel (chr_tbl_sel),
        .cart_d_out  (cart_d_out),
        .xcvr_dir    (xcvr_dir),
        .xcvr_oe_n   (xcvr_oe_n)
    );

endmodule

// File: rtl/cart_bus_bridge_chk.sv
module cart_bus_bridge_chk #(
    parameter int ACT_CLKS = 4,
    parameter int REC_CLKS = 2,
    parameter bit AEN_GATE = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic host_aen,
    input logic host_ack,
    input logic prg_m2,
    input logic prg_romsel_n,
    input logic prg_rw,
    input logic chr_rd_n,
    input logic xcvr_dir,
    input logic xcvr_oe_n
);
    logic [15:0] hi_cnt;
    logic [15:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            lo_cnt <= 16'(REC_CLKS);
        end else if (prg_m2) begin
            hi_cnt <= hi_cnt + 1'b1;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= '0;
            if (lo_cnt != 16'hFFFF) lo_cnt <= lo_cnt + 1'b1;
        end
    end

    // R2
    romsel_only_with_m2_chk: assert property (@(posedge clk) disable iff (rst)
        !prg_romsel_n |-> prg_m2);

    // R4
    dir_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        xcvr_dir |-> !xcvr_oe_n);

    // R5
    write_low_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
        !prg_rw |-> (!prg_romsel_n && xcvr_dir));

    // R3
    chr_read_excludes_prg_chk: assert property (@(posedge clk) disable iff (rst)
        !chr_rd_n |-> (prg_romsel_n && prg_m2));

    // R6
    m2_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(prg_m2) |-> (hi_cnt == 16'(ACT_CLKS)));

    // R7
    m2_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(prg_m2) |-> (lo_cnt >= 16'(REC_CLKS)));

    // R8
    ack_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    // R8
    ack_with_m2_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(host_ack) |-> $fell(prg_m2));

    // R9
    aen_blocks_start_chk: assert property (@(posedge clk) disable iff (rst)
        (AEN_GATE && host_aen) |=> !$rose(prg_m2));

endmodule

bind cart_bus_bridge cart_bus_bridge_chk #(
    .ACT_CLKS(ACT_CLKS),
    .REC_CLKS(REC_CLKS),
    .AEN_GATE(AEN_GATE)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .host_aen    (host_aen),
    .host_ack    (host_ack),
    .prg_m2      (prg_m2),
    .prg_romsel_n(prg_romsel_n),
    .prg_rw      (prg_rw),
    .chr_rd_n    (chr_rd_n),
    .xcvr_dir    (xcvr_dir),
    .xcvr_oe_n   (xcvr_oe_n)
);

// File: tb/cart_bus_bridge_tb_top.sv
module cart_bus_bridge_tb_top;
    localparam int ACT = 5;
    localparam int REC = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ce_n = 1'b1;
    logic        host_rd_n = 1'b1;
    logic        host_wr_n = 1'b1;
    logic        host_aen = 1'b0;
    logic        host_ale = 1'b0;
    logic [7:0]  host_rdata;
    logic        host_ack;
    logic        prg_m2, prg_romsel_n, prg_rw;
    logic [14:0] prg_addr;
    logic [12:0] chr_addr;
    logic        chr_rd_n, chr_wr_n, chr_tbl_sel;
    logic [7:0]  cart_d_in, cart_d_out;
    logic        xcvr_dir, xcvr_oe_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [7:0] cart_bank = 8'h00;
    logic [7:0] bank_m = 8'h00;
    logic [7:0] last_rd = 8'h00;
    int low_run = 1000;
    logic m2_prev = 1'b0;

    always #2 clk = ~clk;

    cart_bus_bridge #(.ACT_CLKS(ACT), .REC_CLKS(REC)) dut_i (.*);

    function automatic logic [7:0] prg_byte(input logic [7:0] b, input logic [14:0] a);
        return a[7:0] ^ b ^ {1'b0, a[14:8]};
    endfunction

    function automatic logic [7:0] chr_byte(input logic [12:0] a);
        return ~a[7:0] ^ {3'b000, a[12:8]};
    endfunction

    // Cartridge model: ROM contents depend on the mapper bank register.
    assign cart_d_in = (!prg_romsel_n && prg_rw) ? prg_byte(cart_bank, prg_addr) :
                       (!chr_rd_n ? chr_byte(chr_addr) : 8'hEE);

    always @(negedge clk)
        if (!prg_romsel_n && !prg_rw && xcvr_dir && !xcvr_oe_n)
            cart_bank <= cart_d_out;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R7 recovery-gap monitor at the ports.
    always @(negedge clk) begin
        if (!rst) begin
            if (prg_m2 && !m2_prev) chk(low_run >= REC, "R7 m2 low gap", low_run, REC);
            if (!prg_m2) low_run = low_run + 1; else low_run = 0;
            m2_prev = prg_m2;
        end
    end

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                chk(1'b0, "watchdog", cycles, 150000);
                finish_run();
            end
        end
    end

    task automatic release_bus();
        host_ce_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1; host_aen = 1'b0;
    endtask

    // Request that must not start a cycle (R9).
    task automatic blocked_access(input logic [15:0] a, input logic aen, input logic both);
        int seen_m2 = 0;
        int seen_ack = 0;
        @(negedge clk);
        host_addr = a; host_aen = aen; host_ce_n = 1'b0;
        host_rd_n = 1'b0; host_wr_n = both ? 1'b0 : 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (prg_m2) seen_m2++;
            if (host_ack) seen_ack++;
        end
        release_bus();
        chk(seen_m2 == 0, "R9 no m2 when blocked", seen_m2, 0);
        chk(seen_ack == 0, "R9 no ack when blocked", seen_ack, 0);
    endtask

    task automatic access(input logic [15:0] a, input logic wr, input logic [7:0] d);
        int hi = 0;
        int acks = 0;
        logic got = 1'b0;
        logic s_rom = 1'b0, s_chr = 1'b0, s_oe = 1'b0, s_dir = 1'b0, s_rwl = 1'b0;
        logic s_chrw = 1'b0, addr_ok = 1'b1, data_ok = 1'b1;
        @(negedge clk);
        host_addr = a; host_wdata = d; host_ce_n = 1'b0;
        host_rd_n = wr; host_wr_n = !wr;
        for (int i = 0; i < 40 && !got; i++) begin
            @(negedge clk);
            if (prg_m2) hi++;
            if (!prg_romsel_n) begin
                s_rom = 1'b1;
                if (prg_addr != a[14:0]) addr_ok = 1'b0;
            end
            if (!chr_rd_n) begin
                s_chr = 1'b1;
                if (chr_addr != a[12:0] || chr_tbl_sel != 1'b0) addr_ok = 1'b0;
            end
            if (!chr_wr_n) s_chrw = 1'b1;
            if (!xcvr_oe_n) s_oe = 1'b1;
            if (xcvr_dir) begin
                s_dir = 1'b1;
                if (cart_d_out != d) data_ok = 1'b0;
            end
            if (!prg_rw) s_rwl = 1'b1;
            if (host_ack) begin
                got = 1'b1;
                acks++;
                chk(!prg_m2, "R8 ack with m2 low", prg_m2, 0);
            end
        end
        release_bus();
        chk(got, "R8 ack seen", got, 1);
        chk(hi == ACT, "R6 m2 high width", hi, ACT);
        chk(addr_ok, "R2/R3 address routing", addr_ok, 1);
        @(negedge clk);
        chk(!host_ack, "R8 ack single pulse", host_ack, 0);
        if (!a[15] && !wr) begin
            chk(host_rdata == chr_byte(a[12:0]), "R3 chr read data", host_rdata, chr_byte(a[12:0]));
            chk(s_chr && !s_rom && !s_dir, "R3 chr strobes", {s_chr, s_rom, s_dir}, 3'b100);
            last_rd = host_rdata;
        end else if (a[15] && !wr) begin
            chk(host_rdata == prg_byte(bank_m, a[14:0]), "R2 prg read data",
                host_rdata, prg_byte(bank_m, a[14:0]));
            chk(s_rom && !s_chr && !s_rwl && !s_dir, "R2 prg read strobes",
                {s_rom, s_chr, s_rwl, s_dir}, 4'b1000);
            last_rd = host_rdata;
        end else if (a[15] && wr) begin
            chk(s_rom && s_rwl && s_dir && s_oe && data_ok, "R4 mapper write",
                {s_rom, s_rwl, s_dir, s_oe, data_ok}, 5'b11111);
            bank_m = d;
            chk(host_rdata == last_rd, "R8 rdata kept over write", host_rdata, last_rd);
        end else begin
            chk(!s_rom && !s_chr && !s_chrw && !s_oe && !s_rwl && !s_dir, "R5 lower write swallowed",
                {s_rom, s_chr, s_chrw, s_oe, s_rwl, s_dir}, 0);
            chk(host_rdata == last_rd, "R8 rdata kept over dropped write", host_rdata, last_rd);
        end
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!prg_m2 && !host_ack && prg_romsel_n && chr_rd_n && chr_wr_n && xcvr_oe_n,
            "R1 reset outputs", {prg_m2, host_ack, prg_romsel_n, chr_rd_n, chr_wr_n, xcvr_oe_n},
            6'b001111);
        chk(host_rdata == 8'h00, "R1 reset rdata", host_rdata, 0);

        // Directed corners.
        access(16'h8123, 1'b0, 8'h00);           // R2 read, bank 0
        access(16'h8000, 1'b1, 8'h3C);           // R4 mapper write
        access(16'h8123, 1'b0, 8'h00);           // R2 read sees new bank
        access(16'h0ABC, 1'b0, 8'h00);           // R3 chr read
        access(16'h6ABC, 1'b0, 8'h00);           // R3 alias of bits 14:13
        chk(host_rdata == chr_byte(13'h0ABC), "R3 alias same byte", host_rdata, chr_byte(13'h0ABC));
        access(16'h1234, 1'b1, 8'h77);           // R5 swallowed write
        access(16'hC001, 1'b0, 8'h00);           // R5 bank unchanged
        chk(cart_bank == bank_m, "R5 mapper state unchanged", cart_bank, bank_m);
        blocked_access(16'h8001, 1'b1, 1'b0);    // R9 aen gate
        blocked_access(16'h8001, 1'b0, 1'b1);    // R9 both strobes
        host_ale = 1'b1;
        access(16'hFFFF, 1'b0, 8'h00);           // R10 ale ignored when TRIG_ALE=0
        host_ale = 1'b0;
        access(16'h7FFF, 1'b0, 8'h00);           // R3 boundary of lower half

        // Constrained random mix.
        for (int n = 0; n < 120; n++) begin
            logic [15:0] a;
            logic        w;
            int          r;
            a = 16'($urandom);
            r = int'($urandom_range(0, 9));
            w = (r < 3);
            if (r == 9) blocked_access(a, 1'b1, 1'b0);
            else access(a, w, 8'($urandom));
        end

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule